// File: doc/BRIEF.md
# Edge-Stepped Noise Register

This block is the noise source of an audio oscillator. It follows one bit of an external 24-bit phase accumulator, the bit of weight 2^19. The accumulator is not part of this block. Each time that bit goes from low to high between two consecutive clock cycles, a 23-bit Fibonacci shift register advances by one step. The shift rate therefore follows the oscillator frequency and not the system clock.

Eight bits spread across the register form the top byte of a 12-bit noise sample, and the low nibble of the sample is zero. That top byte is also the 8-bit value that a host reads back as the oscillator readout. A test input holds the register at its current value. The edge history keeps updating while the test input is high, so a rising edge that happens during the hold is not stepped later.

Top module: `nz_noise_source`

## Requirements
- R1: While `rst` is high at a clock edge, `lfsr_state` loads 0x7FFFF8 and `noise_out` becomes 0xFE0, which is the tap mapping of that seed.
- R2: `lfsr_state` steps only when `phase_tap` is 1 in the current cycle and was 0 in the previous cycle. A level that stays low, a level that stays high and a falling level leave the register unchanged.
- R3: One step moves every register bit up by one position, discards bit 22, and sets the new bit 0 to the XOR of old bits 22 and 17.
- R4: While `hold` is high, `lfsr_state` does not change, whatever `phase_tap` does.
- R5: The previous-level history updates in every cycle, including hold cycles. A rising edge that occurs while `hold` is high is lost: it causes no step after `hold` falls, even if `phase_tap` stays high.
- R6: `noise_out` bits 11 down to 4 equal `lfsr_state` bits 22, 20, 16, 13, 11, 7, 4 and 2, in that order, in the same cycle as the state they come from. Bits [11:4] form the 8-bit readout value.
- R7: `noise_out` bits 3..0 are always zero.
- R8: Reset clears the edge history to 0. A `phase_tap` that is high in the first cycle after reset therefore counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_tap | input | 1 | Accumulator bit of weight 2^19 |
| hold | input | 1 | Test hold; freezes the register |
| noise_out | output | 12 | Registered noise sample |
| lfsr_state | output | 23 | Raw shift register contents |

## Verification
The hardest case to reach is an edge swallowed by the hold: `phase_tap` must rise while `hold` is high and stay high after `hold` drops. Only then does the updated history show up as a missing step. Directed sequences build this case and its mirror, a hold that is released before the edge arrives. Random phases with a low hold rate then produce many lone rising edges, steady levels and falling edges. The bench model advances its own register and compares it with `lfsr_state` after every cycle.

// File: rtl/nz_pkg.sv
package nz_pkg;
  localparam int unsigned LFSR_W  = 23;
  localparam int unsigned FB_HI   = 22;
  localparam int unsigned FB_LO   = 17;
  localparam int unsigned OUT_W   = 12;
  localparam int unsigned N_TAPS  = 8;
  localparam logic [LFSR_W-1:0] SEED = 23'h7FFFF8;
  // register bit feeding output bit (OUT_W-1-i)
  localparam int unsigned TAP_POS [N_TAPS] = '{22, 20, 16, 13, 11, 7, 4, 2};
endpackage

// File: rtl/nz_edge_detect.sv
module nz_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic prev_q,
  output logic rise
);
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/nz_lfsr_core.sv
module nz_lfsr_core #(
  parameter int unsigned W     = 23,
  parameter int unsigned FB_A  = 22,
  parameter int unsigned FB_B  = 17,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] state_q,
  output logic [W-1:0] state_d
);
  logic feedback;

  always_comb begin
    feedback = state_q[FB_A] ^ state_q[FB_B];
    state_d  = step ? {state_q[W-2:0], feedback} : state_q;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/nz_tap_map.sv
module nz_tap_map
  import nz_pkg::*;
(
  input  logic [LFSR_W-1:0] state,
  output logic [OUT_W-1:0]  sample
);
  localparam int unsigned PAD_W = OUT_W - N_TAPS;

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    assign sample[OUT_W-1-i] = state[TAP_POS[i]];
  end
  assign sample[PAD_W-1:0] = '0;
endmodule

// File: rtl/nz_noise_source.sv
module nz_noise_source
  import nz_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_tap,
  input  logic              hold,
  output logic [OUT_W-1:0]  noise_out,
  output logic [LFSR_W-1:0] lfsr_state
);
  logic              prev_tap;
  logic              tap_rise;
  logic              do_step;
  logic [LFSR_W-1:0] state_next;
  logic [OUT_W-1:0]  sample_next;

  nz_edge_detect u_edge (
    .clk    (clk),
    .rst    (rst),
    .level  (phase_tap),
    .prev_q (prev_tap),
    .rise   (tap_rise)
  );

  assign do_step = tap_rise & ~hold;

  nz_lfsr_core #(
    .W    (LFSR_W),
    .FB_A (FB_HI),
    .FB_B (FB_LO),
    .SEED (SEED)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .step    (do_step),
    .state_q (lfsr_state),
    .state_d (state_next)
  );

  // map the next state so the registered sample lines up with lfsr_state
  nz_tap_map u_map (
    .state  (state_next),
    .sample (sample_next)
  );

  always_ff @(posedge clk) begin
    if (rst) noise_out <= '0 | {SEED[22], SEED[20], SEED[16], SEED[13],
                               SEED[11], SEED[7], SEED[4], SEED[2], 4'b0000};
    else     noise_out <= sample_next;
  end
endmodule

// File: rtl/nz_noise_source_chk.sv
module nz_noise_source_chk
  import nz_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              phase_tap,
  input logic              hold,
  input logic              prev_tap,
  input logic [OUT_W-1:0]  noise_out,
  input logic [LFSR_W-1:0] lfsr_state
);
  p_seed_r1: assert property (@(posedge clk) rst |=> lfsr_state == SEED);

  p_no_edge_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !(phase_tap && !prev_tap) |=> $stable(lfsr_state));

  p_step_rule_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_tap && !prev_tap && !hold) |=>
      lfsr_state == {$past(lfsr_state[21:0]), $past(lfsr_state[22] ^ lfsr_state[17])});

  p_hold_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(lfsr_state));

  p_history_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> prev_tap == $past(phase_tap));

  p_map_r6: assert property (@(posedge clk) disable iff (rst)
    noise_out[11:4] == {lfsr_state[22], lfsr_state[20], lfsr_state[16], lfsr_state[13],
                        lfsr_state[11], lfsr_state[7], lfsr_state[4], lfsr_state[2]});

  p_low_zero_r7: assert property (@(posedge clk) disable iff (rst)
    noise_out[3:0] == 4'h0);

  p_reset_hist_r8: assert property (@(posedge clk) rst |=> !prev_tap);
endmodule

bind nz_noise_source nz_noise_source_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .phase_tap  (phase_tap),
  .hold       (hold),
  .prev_tap   (prev_tap),
  .noise_out  (noise_out),
  .lfsr_state (lfsr_state)
);

// File: tb/nz_noise_source_tb.sv
module nz_noise_source_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phase_tap = 1'b0;
  logic        hold = 1'b0;
  logic [11:0] noise_out;
  logic [22:0] lfsr_state;

  int checks = 0;
  int errors = 0;
  logic [22:0] m_state;
  logic        m_prev;

  always #4 clk = ~clk;

  nz_noise_source dut_i (
    .clk(clk), .rst(rst), .phase_tap(phase_tap), .hold(hold),
    .noise_out(noise_out), .lfsr_state(lfsr_state)
  );

  function automatic logic [22:0] f_step(input logic [22:0] s);
    return {s[21:0], s[22] ^ s[17]};
  endfunction

  function automatic logic [11:0] f_map(input logic [22:0] s);
    return {s[22], s[20], s[16], s[13], s[11], s[7], s[4], s[2], 4'h0};
  endfunction

  task automatic check(input string req, input logic [22:0] exp_s);
    checks++;
    if (lfsr_state !== exp_s) begin
      errors++;
      $display("FAIL %s state: got %h expected %h", req, lfsr_state, exp_s);
    end
    checks++;
    if (noise_out !== f_map(exp_s)) begin
      errors++;
      $display("FAIL %s noise: got %h expected %h", req, noise_out, f_map(exp_s));
    end
  endtask

  task automatic step(input logic t, input logic h, input string req);
    @(negedge clk);
    phase_tap = t;
    hold = h;
    @(posedge clk);
    if (t && !m_prev && !h) m_state = f_step(m_state);
    m_prev = t;
    #2;
    check(req, m_state);
  endtask

  task automatic do_reset(input logic t);
    @(negedge clk);
    rst = 1'b1; phase_tap = t; hold = 1'b0;
    @(posedge clk); #2;
    rst = 1'b0;
    m_state = 23'h7FFFF8;
    m_prev = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset(1'b0);
    check("R1", 23'h7FFFF8);
    checks++;
    if (noise_out !== 12'hFE0) begin
      errors++;
      $display("FAIL R1 seed noise: got %h expected fe0", noise_out);
    end
    // R2: steady low, one rise, steady high, fall
    step(0, 0, "R2"); step(1, 0, "R2 R3"); step(1, 0, "R2"); step(1, 0, "R2");
    step(0, 0, "R2"); step(0, 0, "R2"); step(1, 0, "R3");
    // R4: hold freezes across toggling
    step(0, 1, "R4"); step(1, 1, "R4"); step(0, 1, "R4"); step(1, 1, "R4");
    // R5: edge during hold not replayed when hold drops with tap still high
    step(1, 0, "R5"); step(1, 0, "R5"); step(0, 0, "R5"); step(1, 0, "R5 R3");
    // R5 mirror: hold released before edge
    step(0, 1, "R5"); step(0, 0, "R5"); step(1, 0, "R5");
    // R8: tap high in first cycle after reset is an edge
    do_reset(1'b1);
    check("R1", 23'h7FFFF8);
    step(1, 0, "R8");
    checks++;
    if (lfsr_state !== f_step(23'h7FFFF8)) begin
      errors++;
      $display("FAIL R8 state: got %h expected %h", lfsr_state, f_step(23'h7FFFF8));
    end
    // alternating fast edges, then random mix (R6, R7 via f_map)
    for (int i = 0; i < 200; i++) step(i[0], 0, "R3 R6 R7");
    for (int i = 0; i < 4000; i++)
      step(1'($urandom() & 1), ($urandom() % 8) == 0, "R2 R4 R6 R7");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule